// File: doc/BRIEF.md
# DMA Submission Register Front End

This block is the register-facing control side of a single-channel DMA engine. Software uses a 32-bit word-addressed register port to program the control word, the interrupt mask, and a staging copy of the next transfer descriptor. The descriptor holds the addresses, strides, lengths and mode flags. Software then commits the staged descriptor with a start write. The block stamps each committed descriptor with a rotating 5-bit transfer tag. It moves the descriptor into a small queue, and it offers the queue head to a back-end transfer engine through a valid/ready handshake.

The engine reports each finished transfer by its tag, and may mark the completion as partial. These reports land in a done bitmap that software reads. Two interrupt events are raised internally. The first fires when a staged descriptor moves into the queue, which also means the staging slot is free again. The second fires when a transfer completes. Both events pass through a mask to the single interrupt line. Build parameters select which features exist: the implemented X length width, two-dimensional support, and cyclic support. Software discovers them by writing a register and reading it back.

Top module: `dmac_regfront`

## Requirements
- R1: After reset, all of the following hold. Mask reads 0x3. Pending and source read 0. The irq output is 0. Control reads 0. Start reads 0. The tag register reads 0. Done reads 0. The eng_valid output is 0.
- R2: Control bit 0 enables the channel and bit 1 pauses it; eng_enable/eng_pause mirror them, and eng_valid is high only when the queue holds a descriptor while enabled and not paused. Writing control with bit 0 clear discards the staged descriptor and every queued one.
- R3: A write with bit 0 set to start (0x408) commits the staged descriptor only when the channel is enabled and the staging slot is empty. Otherwise the write is ignored. Start reads 1 while the staging slot is occupied, and 0 otherwise.
- R4: The tag register (0x404) reads the tag the next commit will receive. The tag advances by one per commit, wraps from 31 to 0, and is not changed by an abort.
- R5: Up to QDEPTH descriptors wait in the queue, plus one in staging. They reach the engine in commit order, with their tag and all programmed fields intact.
- R6: A completion sets bit <tag> of done (0x428). Committing a descriptor with that tag clears the bit. A partial completion also sets a partial flag. Done bit 31 reads the OR of the partial flag and the done bit for tag 31. Writing done with bit 31 set clears the partial flag.
- R7: Source (0x88) holds raw sticky events: bit 0 for staging-to-queue moves and bit 1 for completions. Pending (0x84) reads source AND NOT mask (0x80). Writing 1 to a pending bit clears that event. The irq output is the OR of the pending bits.
- R8: X length (0x418) keeps only LEN_BITS bits, so writing all ones reads back 2^LEN_BITS-1. Y length (0x41C) reads 0 when 2D support is absent. Flags (0x40C) keep bits 2:0, except that bit 0 reads 0 when cyclic support is absent.
- R9: A read of an unmapped offset returns 0, and a write to one changes nothing.
- R10: Read data appears on rsp_rdata in the cycle after the read request. In any other cycle rsp_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address, word aligned |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after request |
| irq | output | 1 | Interrupt line |
| eng_enable | output | 1 | Channel enabled |
| eng_pause | output | 1 | Channel paused |
| eng_valid | output | 1 | Queue head offered to engine |
| eng_ready | input | 1 | Engine takes queue head |
| eng_id | output | 5 | Tag of queue head |
| eng_flags | output | 3 | Mode flags of queue head |
| eng_dst_addr | output | 32 | Destination address |
| eng_src_addr | output | 32 | Source address |
| eng_xlen | output | 32 | X length minus one |
| eng_ylen | output | 32 | Y length minus one |
| eng_dst_stride | output | 32 | Destination stride |
| eng_src_stride | output | 32 | Source stride |
| cpl_valid | input | 1 | Completion report |
| cpl_id | input | 5 | Tag of completed transfer |
| cpl_partial | input | 1 | Completion was partial |

## Verification
The submission path is first exercised with directed sequences. One sequence overfills the queue to separate the queue depth from the staging slot. One pauses and one aborts to separate a held queue from a discarded one. Another commits while disabled or busy to show the ignored start. A seeded random stream of descriptors with random fields and random partial completions then runs the tag through its wrap. During that stream, each read of the done bitmap is compared with a bench model. These reads show whether a reused tag clears its old bit, and whether bit 31 merges the partial flag. A second instance, built without cyclic and 2D support and with a narrower length field, receives the same writes. Its readbacks must differ from the full instance's only in the feature fields.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int TAG_W = 5;

  localparam int OFF_MASK    = 'h080;
  localparam int OFF_PEND    = 'h084;
  localparam int OFF_SRC     = 'h088;
  localparam int OFF_CTRL    = 'h400;
  localparam int OFF_TAG     = 'h404;
  localparam int OFF_START   = 'h408;
  localparam int OFF_FLAGS   = 'h40C;
  localparam int OFF_DADDR   = 'h410;
  localparam int OFF_SADDR   = 'h414;
  localparam int OFF_XLEN    = 'h418;
  localparam int OFF_YLEN    = 'h41C;
  localparam int OFF_DSTRIDE = 'h420;
  localparam int OFF_SSTRIDE = 'h424;
  localparam int OFF_DONE    = 'h428;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [2:0]       flags;
    logic [31:0]      dst;
    logic [31:0]      src;
    logic [31:0]      xlen;
    logic [31:0]      ylen;
    logic [31:0]      dstride;
    logic [31:0]      sstride;
  } xfer_desc_t;

endpackage

// File: rtl/dmac_irq_ctrl.sv
module dmac_irq_ctrl #(
  parameter int N_EV = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] ev_set,
  input  logic            clr_wr,
  input  logic [N_EV-1:0] clr_data,
  input  logic            mask_wr,
  input  logic [N_EV-1:0] mask_data,
  output logic [N_EV-1:0] raw_q,
  output logic [N_EV-1:0] mask_q,
  output logic [N_EV-1:0] pend,
  output logic            irq_o
);

  logic [N_EV-1:0] raw_d, mask_d;

  always_comb begin
    raw_d = raw_q;
    if (clr_wr) raw_d = raw_d & ~clr_data;
    raw_d  = raw_d | ev_set;
    mask_d = mask_wr ? mask_data : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '1;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign pend  = raw_q & ~mask_q;
  assign irq_o = |pend;

  // an event is never lost, even against a simultaneous clear
  assert_event_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set != '0) |=> ((raw_q & $past(ev_set)) == $past(ev_set)));

endmodule

// File: rtl/dmac_desc_queue.sv
module dmac_desc_queue
  import dmac_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       push,
  input  xfer_desc_t push_desc,
  input  logic       pop,
  output xfer_desc_t head,
  output logic       full,
  output logic       empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  xfer_desc_t     slot_q [DEPTH];
  logic [PW-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = bump(wr_q);
      if (pop)  rd_d = bump(rd_q);
      cnt_d = cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) slot_q[wr_q] <= push_desc;
  end

  assign head  = slot_q[rd_q];
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_no_push_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);

endmodule

// File: rtl/dmac_tag_tracker.sv
module dmac_tag_tracker
  import dmac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             cpl_valid,
  input  logic [TAG_W-1:0] cpl_tag,
  input  logic             cpl_partial,
  input  logic             part_clr,
  output logic [TAG_W-1:0] next_tag_q,
  output logic [31:0]      done_q,
  output logic             part_q
);

  logic [TAG_W-1:0] next_tag_d;
  logic [31:0]      done_d;
  logic             part_d;

  always_comb begin
    next_tag_d = commit ? next_tag_q + 1'b1 : next_tag_q;
    done_d     = done_q;
    if (cpl_valid) done_d[cpl_tag] = 1'b1;
    if (commit)    done_d[next_tag_q] = 1'b0;
    part_d = part_q;
    if (part_clr)                  part_d = 1'b0;
    if (cpl_valid && cpl_partial)  part_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_tag_q <= '0;
      done_q     <= '0;
      part_q     <= 1'b0;
    end else begin
      next_tag_q <= next_tag_d;
      done_q     <= done_d;
      part_q     <= part_d;
    end
  end

  assert_tag_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (next_tag_q == $past(next_tag_q) + 5'd1));
  assert_done_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !(commit && cpl_tag == next_tag_q)) |=> done_q[$past(cpl_tag)]);
  assert_done_reuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !(cpl_valid && cpl_tag == next_tag_q)) |=> !done_q[$past(next_tag_q)]);

endmodule

// File: rtl/dmac_regfront.sv
module dmac_regfront
  import dmac_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int QDEPTH     = 4,
  parameter int LEN_BITS   = 24,
  parameter bit HAS_CYCLIC = 1'b1,
  parameter bit HAS_2D     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  output logic              irq,
  output logic              eng_enable,
  output logic              eng_pause,
  output logic              eng_valid,
  input  logic              eng_ready,
  output logic [4:0]        eng_id,
  output logic [2:0]        eng_flags,
  output logic [31:0]       eng_dst_addr,
  output logic [31:0]       eng_src_addr,
  output logic [31:0]       eng_xlen,
  output logic [31:0]       eng_ylen,
  output logic [31:0]       eng_dst_stride,
  output logic [31:0]       eng_src_stride,
  input  logic              cpl_valid,
  input  logic [4:0]        cpl_id,
  input  logic              cpl_partial
);

  localparam logic [31:0] LEN_MASK = 32'((64'd1 << LEN_BITS) - 1);

  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_PEND    = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_SRC     = ADDR_W'(OFF_SRC);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_TAG     = ADDR_W'(OFF_TAG);
  localparam logic [ADDR_W-1:0] A_START   = ADDR_W'(OFF_START);
  localparam logic [ADDR_W-1:0] A_FLAGS   = ADDR_W'(OFF_FLAGS);
  localparam logic [ADDR_W-1:0] A_DADDR   = ADDR_W'(OFF_DADDR);
  localparam logic [ADDR_W-1:0] A_SADDR   = ADDR_W'(OFF_SADDR);
  localparam logic [ADDR_W-1:0] A_XLEN    = ADDR_W'(OFF_XLEN);
  localparam logic [ADDR_W-1:0] A_YLEN    = ADDR_W'(OFF_YLEN);
  localparam logic [ADDR_W-1:0] A_DSTRIDE = ADDR_W'(OFF_DSTRIDE);
  localparam logic [ADDR_W-1:0] A_SSTRIDE = ADDR_W'(OFF_SSTRIDE);
  localparam logic [ADDR_W-1:0] A_DONE    = ADDR_W'(OFF_DONE);

  // synchronous release of the asynchronous reset
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  // feature variants
  logic [31:0] ylen_keep;
  logic        cyc_keep;
  generate
    if (HAS_2D) begin : g_2d
      assign ylen_keep = LEN_MASK;
    end else begin : g_1d
      assign ylen_keep = '0;
    end
    if (HAS_CYCLIC) begin : g_cyc
      assign cyc_keep = 1'b1;
    end else begin : g_nocyc
      assign cyc_keep = 1'b0;
    end
  endgenerate

  logic wr, rd;
  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  logic ctrl_wr, start_wr, abort;
  assign ctrl_wr  = wr && (req_addr == A_CTRL);
  assign start_wr = wr && (req_addr == A_START) && req_wdata[0];
  assign abort    = ctrl_wr && !req_wdata[0];

  // control and staging state
  logic       en_q, en_d, pause_q, pause_d;
  logic       stage_full_q, stage_full_d;
  xfer_desc_t stg_q, stg_d;

  logic [TAG_W-1:0] next_tag;
  logic [31:0]      done_bits;
  logic             part_pend;
  logic             q_full, q_empty;
  xfer_desc_t       q_head;
  logic             commit, push, pop;

  assign commit = start_wr && en_q && !stage_full_q;
  assign push   = stage_full_q && !q_full && !abort;

  always_comb begin
    en_d         = en_q;
    pause_d      = pause_q;
    stg_d        = stg_q;
    stage_full_d = stage_full_q;
    if (ctrl_wr) begin
      en_d    = req_wdata[0];
      pause_d = req_wdata[1];
    end
    if (wr) begin
      case (req_addr)
        A_FLAGS:   stg_d.flags   = {req_wdata[2:1], req_wdata[0] & cyc_keep};
        A_DADDR:   stg_d.dst     = req_wdata;
        A_SADDR:   stg_d.src     = req_wdata;
        A_XLEN:    stg_d.xlen    = req_wdata & LEN_MASK;
        A_YLEN:    stg_d.ylen    = req_wdata & ylen_keep;
        A_DSTRIDE: stg_d.dstride = req_wdata;
        A_SSTRIDE: stg_d.sstride = req_wdata;
        default: ;
      endcase
    end
    if (commit) stg_d.tag = next_tag;
    if (abort)       stage_full_d = 1'b0;
    else if (commit) stage_full_d = 1'b1;
    else if (push)   stage_full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q         <= 1'b0;
      pause_q      <= 1'b0;
      stage_full_q <= 1'b0;
      stg_q        <= '0;
    end else begin
      en_q         <= en_d;
      pause_q      <= pause_d;
      stage_full_q <= stage_full_d;
      stg_q        <= stg_d;
    end
  end

  dmac_desc_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_ni),
    .flush     (abort),
    .push      (push),
    .push_desc (stg_q),
    .pop       (pop),
    .head      (q_head),
    .full      (q_full),
    .empty     (q_empty)
  );

  dmac_tag_tracker u_tags (
    .clk         (clk),
    .rst_n       (rst_ni),
    .commit      (commit),
    .cpl_valid   (cpl_valid),
    .cpl_tag     (cpl_id),
    .cpl_partial (cpl_partial),
    .part_clr    (wr && (req_addr == A_DONE) && req_wdata[31]),
    .next_tag_q  (next_tag),
    .done_q      (done_bits),
    .part_q      (part_pend)
  );

  logic [1:0] irq_raw, irq_mask, irq_pend;
  dmac_irq_ctrl #(.N_EV(2)) u_irq (
    .clk       (clk),
    .rst_n     (rst_ni),
    .ev_set    ({cpl_valid, push}),
    .clr_wr    (wr && (req_addr == A_PEND)),
    .clr_data  (req_wdata[1:0]),
    .mask_wr   (wr && (req_addr == A_MASK)),
    .mask_data (req_wdata[1:0]),
    .raw_q     (irq_raw),
    .mask_q    (irq_mask),
    .pend      (irq_pend),
    .irq_o     (irq)
  );

  // engine side
  assign eng_enable     = en_q;
  assign eng_pause      = pause_q;
  assign eng_valid      = !q_empty && en_q && !pause_q;
  assign pop            = eng_valid && eng_ready;
  assign eng_id         = q_head.tag;
  assign eng_flags      = q_head.flags;
  assign eng_dst_addr   = q_head.dst;
  assign eng_src_addr   = q_head.src;
  assign eng_xlen       = q_head.xlen;
  assign eng_ylen       = q_head.ylen;
  assign eng_dst_stride = q_head.dstride;
  assign eng_src_stride = q_head.sstride;

  // read path, one register stage
  logic [31:0] rd_val, rdata_q, rdata_d;
  always_comb begin
    rd_val = '0;
    case (req_addr)
      A_MASK:    rd_val = {30'd0, irq_mask};
      A_PEND:    rd_val = {30'd0, irq_pend};
      A_SRC:     rd_val = {30'd0, irq_raw};
      A_CTRL:    rd_val = {30'd0, pause_q, en_q};
      A_TAG:     rd_val = {27'd0, next_tag};
      A_START:   rd_val = {31'd0, stage_full_q};
      A_FLAGS:   rd_val = {29'd0, stg_q.flags};
      A_DADDR:   rd_val = stg_q.dst;
      A_SADDR:   rd_val = stg_q.src;
      A_XLEN:    rd_val = stg_q.xlen;
      A_YLEN:    rd_val = stg_q.ylen;
      A_DSTRIDE: rd_val = stg_q.dstride;
      A_SSTRIDE: rd_val = stg_q.sstride;
      A_DONE:    rd_val = {done_bits[31] | part_pend, done_bits[30:0]};
      default:   rd_val = '0;
    endcase
    rdata_d = rd ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end
  assign rsp_rdata = rdata_q;

  assert_abort_flush_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    abort |=> (!eng_valid && !stage_full_q));
  assert_commit_busy_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    commit |=> stage_full_q);
  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd |=> (rsp_rdata == 32'd0));

endmodule

// File: tb/dmac_regfront_test.sv
`timescale 1ns/1ps
module dmac_regfront_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic        eng_ready, cpl_valid, cpl_partial;
  logic [4:0]  cpl_id;

  logic [31:0] rsp_rdata, eng_dst_addr, eng_src_addr, eng_xlen, eng_ylen, eng_dst_stride, eng_src_stride;
  logic        irq, eng_enable, eng_pause, eng_valid;
  logic [4:0]  eng_id;
  logic [2:0]  eng_flags;

  logic [31:0] rsp_rdata_l, dst_l, src_l, xl_l, yl_l, ds_l, ss_l;
  logic        irq_l, en_l, pa_l, val_l;
  logic [4:0]  id_l;
  logic [2:0]  fl_l;

  always #4 clk = ~clk;

  dmac_regfront uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .irq(irq),
    .eng_enable(eng_enable), .eng_pause(eng_pause), .eng_valid(eng_valid),
    .eng_ready(eng_ready), .eng_id(eng_id), .eng_flags(eng_flags),
    .eng_dst_addr(eng_dst_addr), .eng_src_addr(eng_src_addr), .eng_xlen(eng_xlen),
    .eng_ylen(eng_ylen), .eng_dst_stride(eng_dst_stride), .eng_src_stride(eng_src_stride),
    .cpl_valid(cpl_valid), .cpl_id(cpl_id), .cpl_partial(cpl_partial));

  dmac_regfront #(.LEN_BITS(16), .HAS_CYCLIC(1'b0), .HAS_2D(1'b0)) uut_lite (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata_l), .irq(irq_l),
    .eng_enable(en_l), .eng_pause(pa_l), .eng_valid(val_l),
    .eng_ready(eng_ready), .eng_id(id_l), .eng_flags(fl_l),
    .eng_dst_addr(dst_l), .eng_src_addr(src_l), .eng_xlen(xl_l),
    .eng_ylen(yl_l), .eng_dst_stride(ds_l), .eng_src_stride(ss_l),
    .cpl_valid(cpl_valid), .cpl_id(cpl_id), .cpl_partial(cpl_partial));

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_done = '0;
  logic        exp_part = 1'b0;
  logic [4:0]  exp_tag = '0;
  logic [31:0] rv, rl;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic [31:0] dl);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata; dl = rsp_rdata_l;
  endtask

  task automatic pop_one();
    @(negedge clk);
    eng_ready = 1'b1;
    @(negedge clk);
    eng_ready = 1'b0;
  endtask

  task automatic complete(input logic [4:0] t, input logic p);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_id = t; cpl_partial = p;
    @(negedge clk);
    cpl_valid = 1'b0; cpl_partial = 1'b0;
    exp_done[t] = 1'b1;
    if (p) exp_part = 1'b1;
  endtask

  // accepted commit: bench-side model of tag and done bitmap
  task automatic commit_ok();
    wr(12'h408, 32'd1);
    exp_done[exp_tag] = 1'b0;
    exp_tag = exp_tag + 5'd1;
  endtask

  function automatic logic [31:0] done_word();
    return {exp_done[31] | exp_part, exp_done[30:0]};
  endfunction

  function automatic bit is_mapped(input logic [11:0] a);
    return (a >= 12'h080 && a <= 12'h088) || (a >= 12'h400 && a <= 12'h428);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd2024);
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    eng_ready = 1'b0; cpl_valid = 1'b0; cpl_id = '0; cpl_partial = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    rd(12'h080, rv, rl); chk("R1 mask", rv, 32'h3);
    rd(12'h084, rv, rl); chk("R1 pending", rv, 32'h0);
    rd(12'h088, rv, rl); chk("R1 source", rv, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(12'h400, rv, rl); chk("R1 control", rv, 32'h0);
    rd(12'h408, rv, rl); chk("R1 start", rv, 32'h0);
    rd(12'h404, rv, rl); chk("R1 tag", rv, 32'h0);
    rd(12'h428, rv, rl); chk("R1 done", rv, 32'h0);
    chk("R1 eng_valid", {31'd0, eng_valid}, 32'd0);

    // R9 unmapped offsets, R10 read timing
    rd(12'h000, rv, rl); chk("R9 unmapped read", rv, 32'h0);
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, rv, rl); chk("R9 unmapped write", rv, 32'h0);
    rd(12'h080, rv, rl); chk("R9 mask untouched", rv, 32'h3);
    wr(12'h410, 32'hCAFE_0000);
    rd(12'h410, rv, rl); chk("R10 data next cycle", rv, 32'hCAFE_0000);
    @(negedge clk); chk("R10 idle zero", rsp_rdata, 32'h0);

    // R8 feature readback on both builds
    wr(12'h418, 32'hFFFF_FFFF);
    rd(12'h418, rv, rl); chk("R8 xlen full", rv, 32'h00FF_FFFF); chk("R8 xlen lite", rl, 32'h0000_FFFF);
    wr(12'h41C, 32'd5);
    rd(12'h41C, rv, rl); chk("R8 ylen full", rv, 32'd5); chk("R8 ylen lite", rl, 32'd0);
    wr(12'h40C, 32'hFF);
    rd(12'h40C, rv, rl); chk("R8 flags full", rv, 32'd7); chk("R8 flags lite", rl, 32'd6);

    // R3 commit while disabled is ignored
    wr(12'h408, 32'd1);
    rd(12'h404, rv, rl); chk("R3 disabled commit tag", rv, 32'd0);
    rd(12'h408, rv, rl); chk("R3 disabled commit start", rv, 32'd0);

    // R2 enable, first descriptor
    wr(12'h400, 32'd1);
    chk("R2 enable out", {31'd0, eng_enable}, 32'd1);
    wr(12'h410, 32'h1000); wr(12'h414, 32'h2000); wr(12'h418, 32'hFF);
    wr(12'h41C, 32'd3); wr(12'h420, 32'h40); wr(12'h424, 32'h80); wr(12'h40C, 32'd2);
    commit_ok();
    @(negedge clk);
    chk("R5 valid", {31'd0, eng_valid}, 32'd1);
    chk("R5 id", {27'd0, eng_id}, 32'd0);
    chk("R5 dst", eng_dst_addr, 32'h1000);
    chk("R5 src", eng_src_addr, 32'h2000);
    chk("R5 xlen", eng_xlen, 32'hFF);
    chk("R5 ylen", eng_ylen, 32'd3);
    chk("R5 strides", {eng_dst_stride[15:0], eng_src_stride[15:0]}, 32'h0040_0080);
    chk("R5 flags", {29'd0, eng_flags}, 32'd2);
    rd(12'h404, rv, rl); chk("R4 tag advance", rv, 32'd1);

    // R7 interrupt path
    rd(12'h088, rv, rl); chk("R7 raw start event", rv, 32'd1);
    rd(12'h084, rv, rl); chk("R7 masked pending", rv, 32'd0);
    chk("R7 masked irq", {31'd0, irq}, 32'd0);
    wr(12'h080, 32'd0);
    rd(12'h084, rv, rl); chk("R7 unmasked pending", rv, 32'd1);
    chk("R7 irq high", {31'd0, irq}, 32'd1);
    wr(12'h084, 32'd1);
    rd(12'h084, rv, rl); chk("R7 w1c", rv, 32'd0);
    chk("R7 irq low", {31'd0, irq}, 32'd0);

    // R2 pause holds the queue
    wr(12'h400, 32'd3);
    chk("R2 paused valid", {30'd0, eng_pause, eng_valid}, 32'd2);
    wr(12'h400, 32'd1);
    chk("R2 resumed valid", {31'd0, eng_valid}, 32'd1);

    pop_one();
    complete(5'd0, 1'b0);
    rd(12'h428, rv, rl); chk("R6 done bit0", rv, done_word());
    rd(12'h084, rv, rl); chk("R7 end event", rv, 32'd2);
    chk("R7 irq end", {31'd0, irq}, 32'd1);
    wr(12'h084, 32'd2);

    // R3/R5 overfill: four queued plus one staged
    for (int i = 1; i <= 5; i++) begin
      wr(12'h418, 32'(i * 16));
      commit_ok();
    end
    rd(12'h408, rv, rl); chk("R3 staging busy", rv, 32'd1);
    wr(12'h408, 32'd1);
    rd(12'h404, rv, rl); chk("R3 busy commit ignored", rv, 32'd6);
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      chk("R5 order id", {27'd0, eng_id}, 32'(i));
      chk("R5 order xlen", eng_xlen, 32'(i * 16));
      pop_one();
    end

    // R2 abort discards staged and queued work; R4 tag kept
    commit_ok(); commit_ok();
    wr(12'h400, 32'd0);
    chk("R2 abort valid", {31'd0, eng_valid}, 32'd0);
    rd(12'h408, rv, rl); chk("R2 abort staging", rv, 32'd0);
    wr(12'h400, 32'd1);
    @(negedge clk);
    chk("R2 queue flushed", {31'd0, eng_valid}, 32'd0);
    rd(12'h404, rv, rl); chk("R4 tag after abort", rv, 32'd8);

    // random stream through the tag wrap
    for (int it = 0; it < 40; it++) begin
      logic [31:0] d, s, x;
      logic [2:0]  f;
      logic        p;
      logic [4:0]  t;
      d = $urandom; s = $urandom; x = $urandom; f = 3'($urandom); p = 1'($urandom);
      wr(12'h410, d); wr(12'h414, s); wr(12'h418, x); wr(12'h40C, {29'd0, f});
      rd(12'h404, rv, rl); chk("R4 tag readback", rv, {27'd0, exp_tag});
      t = exp_tag;
      commit_ok();
      @(negedge clk);
      chk("R5 rand id", {27'd0, eng_id}, {27'd0, t});
      chk("R5 rand dst", eng_dst_addr, d);
      chk("R5 rand src", eng_src_addr, s);
      chk("R8 rand xlen", eng_xlen, x & 32'h00FF_FFFF);
      chk("R5 rand flags", {29'd0, eng_flags}, {29'd0, f});
      pop_one();
      rd(12'h428, rv, rl); chk("R6 reuse clears", rv, done_word());
      complete(t, p);
      rd(12'h428, rv, rl); chk("R6 done after cpl", rv, done_word());
      if (exp_part) begin
        wr(12'h428, 32'h8000_0000);
        exp_part = 1'b0;
        rd(12'h428, rv, rl); chk("R6 partial clear", rv, done_word());
      end
      if (it % 8 == 0) begin
        logic [11:0] a;
        a = 12'($urandom) & 12'hFFC;
        if (!is_mapped(a)) begin
          rd(a, rv, rl); chk("R9 random unmapped", rv, 32'h0);
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule